// File: doc/BRIEF.md
# Banked RAM Array with Chip-Select Decode

This block builds one larger synchronous memory out of several identical small RAM banks. Each bank has its own chip select and its own read/write control. A build-time parameter selects one of two arrangements. In the depth arrangement, the top address bits are decoded into one-hot chip selects, so only one bank answers each access and the word count grows with the number of banks. In the width arrangement, every bank sees the same address and the same control, and each bank holds one byte lane of a wider word.

The block has one external port. It takes an enable, a write strobe, an address and write data, and it returns read data. A write stores its data at the rising edge where the enable and the write strobe are both high. A read is an enabled access with the strobe low, and its data appears on `rdata` after that same edge, so the read latency is one cycle. In the depth arrangement, the output multiplexer is steered by a registered copy of the bank-select bits, which lines it up with the bank output registers. The bank depth, the bank width and the number of select bits are parameters, so a small configuration keeps the same decode structure as a full-size one.

Top module: `bram_array`

## Requirements
- R1: After a synchronous reset, `rdata` is all zeros until the first read.
- R2: In the depth arrangement, the top SEL_BITS address bits pick exactly one bank, with bank index equal to those bits. The low BANK_AW bits pick the word inside that bank. No more than one chip select is ever active.
- R3: A cycle with `en`=1 and `we`=1 stores `wdata` at `addr`. A cycle with `en`=1 and `we`=0 puts the stored word on `rdata` after that rising edge.
- R4: The first word and the last word of every bank are separate storage, so no bank aliases another bank.
- R5: A bank whose chip select is inactive ignores the write. Words at the same in-bank offset in the other banks keep their values.
- R6: While `en` is 0, no chip select is active, nothing is written and `rdata` holds its last value.
- R7: An enabled write does not change `rdata`. It keeps showing the result of the last read.
- R8: In the width arrangement, bank i stores and returns byte lane i (bits i*BANK_DW and up) of the word, and all lanes share the address.
- R9: In the width arrangement, every enabled access asserts all chip selects, so one write updates every lane.
- R10: Reads on consecutive cycles from different banks each return their own word on the cycle after they are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Access enable |
| we | input | 1 | 1 = write, 0 = read (when enabled) |
| addr | input | AW | Word address (BANK_AW+SEL_BITS in depth arrangement, BANK_AW in width arrangement) |
| wdata | input | DW | Write data (BANK_DW, or BANK_DW times bank count in width arrangement) |
| rdata | output | DW | Read data, one cycle after the read |

## Verification
The bench writes a different value to every word of a 4-bank depth configuration and then reads all of them back. A decoder that mixes up the select bits, or that lets two banks share storage, returns the neighbour's value at the first or last word of some bank. It then rewrites a single word and reads the same offset in the other banks, which exposes a chip select that leaks a write into more than one bank. It also holds a write strobe with the enable low, and it checks `rdata` right after a write. A design that gates badly corrupts the memory in the first case or disturbs the read data in the second. Back-to-back reads across banks catch a multiplexer steered by unregistered select bits, which would show the wrong bank for one cycle. A two-bank width configuration checks that each byte lane reaches its own bank.

// File: rtl/bram_pkg.sv
package bram_pkg;

    typedef enum logic {
        ARR_DEPTH = 1'b0,
        ARR_WIDTH = 1'b1
    } arrange_e;

    function automatic int bank_count(input int sel_bits);
        return 1 << sel_bits;
    endfunction

    function automatic int ext_addr_w(input arrange_e arr, input int bank_aw, input int sel_bits);
        return (arr == ARR_DEPTH) ? bank_aw + sel_bits : bank_aw;
    endfunction

    function automatic int ext_data_w(input arrange_e arr, input int bank_dw, input int sel_bits);
        return (arr == ARR_DEPTH) ? bank_dw : bank_dw * bank_count(sel_bits);
    endfunction

endpackage

// File: rtl/bram_bank.sv
module bram_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (cs && we) begin
            store[addr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (cs && !we) begin
            dout <= store[addr];
        end
    end
endmodule

// File: rtl/bram_csdec.sv
module bram_csdec
    import bram_pkg::*;
#(
    parameter int       SEL_BITS = 2,
    parameter arrange_e ARRANGE  = ARR_DEPTH,
    localparam int      NB       = 1 << SEL_BITS
) (
    input  logic                en,
    input  logic [SEL_BITS-1:0] sel,
    output logic [NB-1:0]       cs
);
    generate
        for (genvar i = 0; i < NB; i++) begin : g_cs
            if (ARRANGE == ARR_DEPTH) begin : g_depth
                assign cs[i] = en && (sel == SEL_BITS'(i));
            end else begin : g_width
                assign cs[i] = en;
            end
        end
    endgenerate
endmodule

// File: rtl/bram_rdmux.sv
module bram_rdmux
    import bram_pkg::*;
#(
    parameter int       SEL_BITS = 2,
    parameter int       BANK_DW  = 8,
    parameter arrange_e ARRANGE  = ARR_DEPTH,
    localparam int      NB       = 1 << SEL_BITS,
    localparam int      DW       = ext_data_w(ARRANGE, BANK_DW, SEL_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_take,
    input  logic [SEL_BITS-1:0]   sel,
    input  logic [NB*BANK_DW-1:0] bank_dout,
    output logic [DW-1:0]         rdata
);
    generate
        if (ARRANGE == ARR_DEPTH) begin : g_depth
            logic [SEL_BITS-1:0] sel_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sel_q <= '0;
                end else if (rd_take) begin
                    sel_q <= sel;
                end
            end
            assign rdata = bank_dout[sel_q*BANK_DW +: BANK_DW];
        end else begin : g_width
            assign rdata = bank_dout;
        end
    endgenerate
endmodule

// File: rtl/bram_array.sv
module bram_array
    import bram_pkg::*;
#(
    parameter int       BANK_AW  = 8,
    parameter int       BANK_DW  = 8,
    parameter int       SEL_BITS = 2,
    parameter arrange_e ARRANGE  = ARR_DEPTH,
    localparam int      NB       = 1 << SEL_BITS,
    localparam int      AW       = ext_addr_w(ARRANGE, BANK_AW, SEL_BITS),
    localparam int      DW       = ext_data_w(ARRANGE, BANK_DW, SEL_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [SEL_BITS-1:0]   sel;
    logic [BANK_AW-1:0]    bank_addr;
    logic [NB-1:0]         cs;
    logic [NB*BANK_DW-1:0] bank_din;
    logic [NB*BANK_DW-1:0] bank_dout;

    assign bank_addr = addr[BANK_AW-1:0];

    generate
        if (ARRANGE == ARR_DEPTH) begin : g_sel_depth
            assign sel = addr[AW-1 -: SEL_BITS];
        end else begin : g_sel_width
            assign sel = '0;
        end
    endgenerate

    bram_csdec #(
        .SEL_BITS (SEL_BITS),
        .ARRANGE  (ARRANGE)
    ) u_dec (
        .en  (en),
        .sel (sel),
        .cs  (cs)
    );

    generate
        for (genvar i = 0; i < NB; i++) begin : g_bank
            if (ARRANGE == ARR_DEPTH) begin : g_din_depth
                assign bank_din[i*BANK_DW +: BANK_DW] = wdata;
            end else begin : g_din_width
                assign bank_din[i*BANK_DW +: BANK_DW] = wdata[i*BANK_DW +: BANK_DW];
            end

            bram_bank #(
                .AW (BANK_AW),
                .DW (BANK_DW)
            ) u_bank (
                .clk  (clk),
                .rst  (rst),
                .cs   (cs[i]),
                .we   (we),
                .addr (bank_addr),
                .din  (bank_din[i*BANK_DW +: BANK_DW]),
                .dout (bank_dout[i*BANK_DW +: BANK_DW])
            );
        end
    endgenerate

    bram_rdmux #(
        .SEL_BITS (SEL_BITS),
        .BANK_DW  (BANK_DW),
        .ARRANGE  (ARRANGE)
    ) u_mux (
        .clk       (clk),
        .rst       (rst),
        .rd_take   (en && !we),
        .sel       (sel),
        .bank_dout (bank_dout),
        .rdata     (rdata)
    );
endmodule

// File: rtl/bram_array_chk.sv
module bram_array_chk
    import bram_pkg::*;
#(
    parameter int       NB      = 4,
    parameter int       DW      = 8,
    parameter arrange_e ARRANGE = ARR_DEPTH
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          we,
    input logic [NB-1:0] cs,
    input logic [DW-1:0] rdata
);
    assert_idle_no_cs_R6: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cs == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(rdata));

    assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && we) |=> $stable(rdata));

    generate
        if (ARRANGE == ARR_DEPTH) begin : g_depth
            assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
                $onehot0(cs));
            assert_cs_present_R2: assert property (@(posedge clk) disable iff (rst)
                en |-> ($countones(cs) == 1));
        end else begin : g_width
            assert_cs_all_R9: assert property (@(posedge clk) disable iff (rst)
                en |-> (&cs));
        end
    endgenerate
endmodule

bind bram_array bram_array_chk #(
    .NB      (NB),
    .DW      (DW),
    .ARRANGE (ARRANGE)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .we    (we),
    .cs    (cs),
    .rdata (rdata)
);

// File: tb/bram_array_tb.sv
module bram_array_tb;
    import bram_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic        d_en = 0, d_we = 0;
    logic [5:0]  d_addr = '0;
    logic [7:0]  d_wdata = '0, d_rdata;
    logic        w_en = 0, w_we = 0;
    logic [3:0]  w_addr = '0;
    logic [15:0] w_wdata = '0, w_rdata;

    bram_array #(.BANK_AW(4), .BANK_DW(8), .SEL_BITS(2), .ARRANGE(ARR_DEPTH)) u_dut (
        .clk(clk), .rst(rst), .en(d_en), .we(d_we),
        .addr(d_addr), .wdata(d_wdata), .rdata(d_rdata));

    bram_array #(.BANK_AW(4), .BANK_DW(8), .SEL_BITS(1), .ARRANGE(ARR_WIDTH)) u_dut_wide (
        .clk(clk), .rst(rst), .en(w_en), .we(w_we),
        .addr(w_addr), .wdata(w_wdata), .rdata(w_rdata));

    logic [7:0]  exp_d [64];
    logic [15:0] exp_w [16];

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic d_wr(input int a, input logic [7:0] v);
        d_en = 1; d_we = 1; d_addr = 6'(a); d_wdata = v;
        @(negedge clk);
        exp_d[a] = v;
    endtask

    task automatic d_rd(input int a, input string req);
        d_en = 1; d_we = 0; d_addr = 6'(a);
        @(negedge clk);
        check(req, {8'h00, d_rdata}, {8'h00, exp_d[a]});
    endtask

    task automatic w_wr(input int a, input logic [15:0] v);
        w_en = 1; w_we = 1; w_addr = 4'(a); w_wdata = v;
        @(negedge clk);
        exp_w[a] = v;
    endtask

    task automatic w_rd(input int a, input string req);
        w_en = 1; w_we = 0; w_addr = 4'(a);
        @(negedge clk);
        check(req, w_rdata, exp_w[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 depth", {8'h00, d_rdata}, 16'h0000);
        check("R1 width", w_rdata, 16'h0000);

        // Depth arrangement: fill every word, read all back-to-back
        for (int a = 0; a < 64; a++) d_wr(a, pat(a));
        for (int a = 0; a < 64; a++) d_rd(a, "R2 R3 sweep");
        for (int b = 0; b < 4; b++) begin
            d_rd(b * 16, "R4 first word");
            d_rd(b * 16 + 15, "R4 last word");
        end
        // R10: consecutive reads hopping across banks
        d_rd(5, "R10"); d_rd(53, "R10"); d_rd(21, "R10"); d_rd(37, "R10");

        // R5: rewrite one word of bank 2, siblings untouched
        d_wr(37, 8'hC3);
        d_rd(5, "R5"); d_rd(21, "R5"); d_rd(53, "R5"); d_rd(37, "R5");

        // R6: enable low with write strobe held, output must hold
        d_en = 0; d_we = 1; d_addr = 6'd5; d_wdata = 8'h5A;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 hold", {8'h00, d_rdata}, 16'h00C3);
        end
        d_rd(5, "R6 no write");

        // R7: write after read keeps read data
        d_rd(10, "R7 setup");
        d_wr(50, 8'h77);
        check("R7", {8'h00, d_rdata}, {8'h00, exp_d[10]});
        d_rd(50, "R3 rewrite");
        d_en = 0;

        // Width arrangement: two byte lanes side by side
        for (int a = 0; a < 16; a++) w_wr(a, {pat(a + 64), pat(a)});
        for (int a = 0; a < 16; a++) begin
            w_rd(a, "R8 R9 word");
            check("R8 low lane", {8'h00, w_rdata[7:0]}, {8'h00, pat(a)});
            check("R8 high lane", {8'h00, w_rdata[15:8]}, {8'h00, pat(a + 64)});
        end
        w_wr(15, 16'hA55A);
        w_rd(15, "R9 both lanes");
        w_rd(0, "R9 neighbour");
        w_en = 0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule